// File: doc/BRIEF.md
# Board Interrupt and Control Register Block

The block is a small board controller on a 32-bit register bus. It collects sixteen external interrupt lines into a pending register. A line can set its pending bit only while that line is enabled. The block combines the enabled pending bits into one registered interrupt line toward the host. Software acknowledges an interrupt by writing the pending register directly; a zero in a bit position clears that bit.

Beside the interrupt logic, the block holds eight plain storage words. Software uses them for LED data and control, switch settings and miscellaneous control. The block also holds two card-socket words. In each socket word, software controls the low five bits (power and reset). Each socket word has a fixed ready flag. Each also has an active-low card-detect flag, which follows interrupt line 9 for socket 0 and line 13 for socket 1. The bus has no handshake. A write takes effect on the clock edge where the write strobe is high. Read data is a combinational function of the current address.

Top module: `brd_ctrl`

## Requirements
- R1: After a synchronous active-low reset, these all read zero: the enable word, the pending word and the eight storage words. Both socket words read 0x0000_0420, which is ready bit 10 and card-detect bit 5. The interrupt output is 0.
- R2: The address map uses 8-bit byte addresses. The enable word is at 0x00 and the pending word is at 0x04. Socket 0 is at 0x08 and socket 1 is at 0x0C. Storage word i (i = 0..7) is at 0x10 + 4*i. Each storage word keeps and returns any 32-bit value written to it.
- R3: A write to the enable word or to the pending word stores the data ANDed with 0x000F_EEFF. As a result, bits 8, 12 and 20 to 31 always read as zero.
- R4: A write to the pending word replaces its whole content. Writing 0 to a bit clears that bit.
- R5: An interrupt input that is high at a clock edge sets its pending bit at that edge, but only if its enable bit is already 1. An input whose enable bit is 0 leaves its pending bit at 0.
- R6: Pending bits are sticky. An input that goes low never clears its pending bit.
- R7: The interrupt output is 1 exactly when the pending and enable words, as they stood after the previous clock edge, have at least one set bit in common. The output therefore changes one clock edge after the register change that causes it.
- R8: A bus write to the pending word and an input-driven set can occur at the same edge. In that case the written value wins, and the input-driven set is lost.
- R9: Socket 0 bit 5 reads the inverse of interrupt input 9, and socket 1 bit 5 reads the inverse of input 13. Each is sampled at the previous clock edge. The enable word does not affect these bits.
- R10: A write to a socket word changes only its bits [4:0]. Bit 10 stays 1, bit 5 keeps following its input, and all other bits stay 0.
- R11: A read from any address not in the map returns 0. A write to such an address changes no readable word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_i | input | 8 | Byte address of the register access |
| we_i | input | 1 | Write strobe; the write is taken at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_i | input | 16 | External interrupt lines, active high, level sampled |
| irq_o | output | 1 | Combined interrupt toward the host, registered |

## Verification
Two events can land on the same clock edge. One is a bus write to the pending word. The other is an enabled interrupt input that is high and would set a pending bit. The bench forces this case in two steps. It first enables the line. It then raises the line in the same cycle as a write of zero to the pending word, and drops the line before the next edge. The pending word must then read zero, and the interrupt output must stay low. A second overlap, an acknowledge write while the output is high, is judged by the timing of the output: it must fall exactly one edge after the clearing write.

// File: rtl/brd_pkg.sv
// Package brd_pkg
// Holds the shared address map and field positions of the board controller.
// Assumes word-aligned byte addresses; every listed offset is a multiple of four.
package brd_pkg;
    localparam int OFS_ENABLE  = 'h00;
    localparam int OFS_PENDING = 'h04;
    localparam int OFS_SOCK0   = 'h08;
    localparam int OFS_SOCK1   = 'h0C;
    localparam int OFS_GP_BASE = 'h10;

    localparam int SOCK_CTL_W     = 5;
    localparam int SOCK_CD_BIT    = 5;
    localparam int SOCK_READY_BIT = 10;

    localparam logic [31:0] IRQ_STORE_MASK = 32'h000F_EEFF;
endpackage

// File: rtl/brd_irq_ctrl.sv
// Module brd_irq_ctrl
// Holds the interrupt enable and pending words and produces the combined,
// registered interrupt line. Inputs are level sampled on every edge. A set
// needs the enable bit as it stood before the edge. A bus write to the
// pending word overrides any input-driven set at the same edge.
// Assumes DATA_W > NUM_IRQ and the inputs are already synchronous to clk.
module brd_irq_ctrl #(
    parameter int          NUM_IRQ    = 16,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] STORE_MASK = 32'h000F_EEFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic              en_we_i,
    input  logic              pend_we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] en_o,
    output logic [DATA_W-1:0] pend_o,
    output logic              irq_o
);
    localparam int PAD_W = DATA_W - NUM_IRQ;
    localparam logic [DATA_W-1:0] MASK_W = DATA_W'(STORE_MASK);

    logic [DATA_W-1:0] en_q, en_d;
    logic [DATA_W-1:0] pend_q, pend_d;
    logic [DATA_W-1:0] line_w;
    logic              irq_q;

    assign line_w = {{PAD_W{1'b0}}, irq_i};

    // Next enable word: bus write stores masked data, otherwise hold.
    always_comb begin
        en_d = en_q;
        if (en_we_i) begin
            en_d = wdata_i & MASK_W;
        end
    end

    // Next pending word: bus write replaces, otherwise enabled high lines set.
    always_comb begin
        if (pend_we_i) begin
            pend_d = wdata_i & MASK_W;
        end else begin
            pend_d = pend_q | (line_w & en_q);
        end
    end

    // Register the enable and pending words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
        end else begin
            en_q   <= en_d;
            pend_q <= pend_d;
        end
    end

    // Register the combined interrupt from the current enabled pending bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(pend_q & en_q);
        end
    end

    assign en_o   = en_q;
    assign pend_o = pend_q;
    assign irq_o  = irq_q;

    // R6: without a pending write no set bit is ever lost
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_we_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R5: without a pending write every enabled high line is latched
    p_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_we_i |=> ((pend_q & $past(line_w & en_q)) == $past(line_w & en_q)));

    // R5: a bit that was not enabled never appears through an input
    p_no_stray_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_we_i |=> ((pend_q & ~$past(pend_q) & ~$past(en_q)) == '0));

    // R8: the written value is what the pending word holds after a write
    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_we_i |=> (pend_q == ($past(wdata_i) & MASK_W)));

    // R7: the output only rises after an enabled pending bit existed
    p_irq_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((pend_q & en_q) != '0));
endmodule

// File: rtl/brd_socket_reg.sv
// Module brd_socket_reg
// One card-socket word. Software owns the low control field. The ready
// flag is fixed at one. The card-detect flag is the registered inverse of the
// socket's interrupt line, so it reads zero while a card is signalled.
// Assumes CD_BIT and READY_BIT lie above the control field and below DATA_W.
module brd_socket_reg #(
    parameter int DATA_W    = 32,
    parameter int CTL_W     = 5,
    parameter int CD_BIT    = 5,
    parameter int READY_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              det_line_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [CTL_W-1:0] ctl_q;
    logic             cd_q;

    // Capture the control field on a write to this socket.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we_i) begin
            ctl_q <= wdata_i[CTL_W-1:0];
        end
    end

    // Track the detect line, inverted, one edge behind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_q <= 1'b1;
        end else begin
            cd_q <= ~det_line_i;
        end
    end

    // Assemble the readable word from its fields.
    always_comb begin
        rdata_o                = '0;
        rdata_o[CTL_W-1:0]     = ctl_q;
        rdata_o[CD_BIT]        = cd_q;
        rdata_o[READY_BIT]     = 1'b1;
    end

    // R10: the control field changes only through a write
    p_ctl_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(ctl_q));

    // R9: card detect is the inverse of the line one edge earlier
    p_cd_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cd_q == !$past(det_line_i)));
endmodule

// File: rtl/brd_gp_regs.sv
// Module brd_gp_regs
// A bank of plain read/write storage words on consecutive word addresses,
// used for LED, switch and miscellaneous settings. Has no side effects.
// Assumes BASE is word aligned and the bank fits in the address space.
module brd_gp_regs #(
    parameter int NUM_GP = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int BASE   = 'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              hit_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] gp_q [NUM_GP];
    logic [NUM_GP-1:0] sel_w;

    for (genvar gi = 0; gi < NUM_GP; gi++) begin : g_word
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(BASE + 4 * gi);

        assign sel_w[gi] = (addr_i == WADDR);

        // Store the written word when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gp_q[gi] <= '0;
            end else if (we_i && sel_w[gi]) begin
                gp_q[gi] <= wdata_i;
            end
        end

        // R2: a storage word changes only when written at its own address
        p_gp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && (addr_i == WADDR)) |=> $stable(gp_q[gi]));
    end

    // Select the addressed storage word for the read path.
    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_GP; i++) begin
            if (sel_w[i]) begin
                rdata_o = gp_q[i];
            end
        end
    end

    assign hit_o = |sel_w;
endmodule

// File: rtl/brd_ctrl.sv
// Module brd_ctrl
// Top of the board controller. Decodes the register bus, routes writes to
// the interrupt block, the two sockets and the storage bank, and muxes the
// read data. Unmapped addresses read zero and ignore writes.
// Assumes a single-cycle bus with no handshake.
module brd_ctrl
    import brd_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 8,
    parameter int NUM_GP  = 8,
    parameter int CD0_IRQ = 9,
    parameter int CD1_IRQ = 13
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               we_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_IRQ-1:0] irq_i,
    output logic               irq_o
);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFS_PENDING);
    localparam logic [ADDR_W-1:0] A_S0   = ADDR_W'(OFS_SOCK0);
    localparam logic [ADDR_W-1:0] A_S1   = ADDR_W'(OFS_SOCK1);

    logic              sel_en, sel_pend;
    logic [1:0]        sel_sock;
    logic [DATA_W-1:0] en_w, pend_w, gp_rdata;
    logic [DATA_W-1:0] sock_rdata [2];
    logic              gp_hit;
    logic [1:0]        det_w;

    assign sel_en      = (addr_i == A_EN);
    assign sel_pend    = (addr_i == A_PEND);
    assign sel_sock[0] = (addr_i == A_S0);
    assign sel_sock[1] = (addr_i == A_S1);
    assign det_w       = {irq_i[CD1_IRQ], irq_i[CD0_IRQ]};

    brd_irq_ctrl #(
        .NUM_IRQ    (NUM_IRQ),
        .DATA_W     (DATA_W),
        .STORE_MASK (IRQ_STORE_MASK)
    ) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_i     (irq_i),
        .en_we_i   (we_i && sel_en),
        .pend_we_i (we_i && sel_pend),
        .wdata_i   (wdata_i),
        .en_o      (en_w),
        .pend_o    (pend_w),
        .irq_o     (irq_o)
    );

    for (genvar si = 0; si < 2; si++) begin : g_sock
        brd_socket_reg #(
            .DATA_W    (DATA_W),
            .CTL_W     (SOCK_CTL_W),
            .CD_BIT    (SOCK_CD_BIT),
            .READY_BIT (SOCK_READY_BIT)
        ) u_sock (
            .clk        (clk),
            .rst_n      (rst_n),
            .we_i       (we_i && sel_sock[si]),
            .wdata_i    (wdata_i),
            .det_line_i (det_w[si]),
            .rdata_o    (sock_rdata[si])
        );
    end

    brd_gp_regs #(
        .NUM_GP (NUM_GP),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BASE   (OFS_GP_BASE)
    ) u_gp (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr_i),
        .we_i    (we_i),
        .wdata_i (wdata_i),
        .hit_o   (gp_hit),
        .rdata_o (gp_rdata)
    );

    // Read multiplexer; unmapped addresses fall through to zero.
    always_comb begin
        if (sel_en) begin
            rdata_o = en_w;
        end else if (sel_pend) begin
            rdata_o = pend_w;
        end else if (sel_sock[0]) begin
            rdata_o = sock_rdata[0];
        end else if (sel_sock[1]) begin
            rdata_o = sock_rdata[1];
        end else if (gp_hit) begin
            rdata_o = gp_rdata;
        end else begin
            rdata_o = '0;
        end
    end

    // R3: masked-off bits of the interrupt words never read as one
    p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_w | pend_w) & ~DATA_W'(IRQ_STORE_MASK)) == '0);
endmodule

// File: tb/brd_ctrl_tb.sv
module brd_ctrl_tb;
    localparam logic [31:0] MASK = 32'h000F_EEFF;
    localparam int TIMEOUT_CYC = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [15:0] irq_in = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    logic [31:0] gp_exp [8];

    always #2 clk = ~clk;

    brd_ctrl u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .we_i    (we),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_i   (irq_in),
        .irq_o   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic check_all(input string req, input logic [31:0] en_e, input logic [31:0] pd_e);
        rd_chk(req, 8'h00, en_e);
        rd_chk(req, 8'h04, pd_e);
        rd_chk(req, 8'h08, 32'h420);
        rd_chk(req, 8'h0C, 32'h420);
        for (int i = 0; i < 8; i++) rd_chk(req, 8'(8'h10 + 4 * i), gp_exp[i]);
    endtask

    initial begin
        #(TIMEOUT_CYC * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < 8; i++) gp_exp[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        chk("R1 irq_o", {31'b0, irq_out}, 32'h0);
        check_all("R1", 32'h0, 32'h0);

        // R2: storage words, several patterns each
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 8; i++) begin
                gp_exp[i] = (32'h1 << ((i * 4 + p * 7) % 32)) ^ (32'hA5A5_0000 >> p) ^ 32'(i * 32'h0101_0101);
                wr(8'(8'h10 + 4 * i), gp_exp[i]);
            end
            for (int i = 0; i < 8; i++) rd_chk("R2 storage", 8'(8'h10 + 4 * i), gp_exp[i]);
        end

        // R3: masking of the enable and pending words
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R3 enable mask", 8'h00, MASK);
        wr(8'h00, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);
        rd_chk("R3 pending mask", 8'h04, MASK);
        // R4: pending write replaces contents
        wr(8'h04, 32'h0000_0F0F);
        rd_chk("R4 pending replace", 8'h04, 32'h0000_0E0F);
        wr(8'h04, 32'h0);
        rd_chk("R4 pending clear", 8'h04, 32'h0);

        // R5/R6/R7: sweep every line, enabled and disabled
        for (int k = 0; k < 16; k++) begin
            logic [31:0] bitk;
            bitk = 32'h1 << k;
            wr(8'h00, bitk);
            wr(8'h04, 32'h0);
            @(negedge clk); irq_in = 16'(bitk);
            @(negedge clk); irq_in = '0;
            rd_chk("R5 enabled line latches (R6 sticky)", 8'h04, bitk & MASK);
            chk("R7 irq_o after enabled latch", {31'b0, irq_out}, {31'b0, (bitk & MASK) != 0});
            wr(8'h04, 32'h0);
            wr(8'h00, ~bitk);
            @(negedge clk); irq_in = 16'(bitk);
            @(negedge clk); irq_in = '0;
            rd_chk("R5 disabled line ignored", 8'h04, 32'h0);
            chk("R5 irq_o disabled", {31'b0, irq_out}, 32'h0);
        end
        wr(8'h00, 32'h0);

        // R6: accumulation of several lines, all stay set
        wr(8'h00, 32'h0000_00F0);
        @(negedge clk); irq_in = 16'h0010;
        @(negedge clk); irq_in = 16'h0080;
        @(negedge clk); irq_in = 16'h0000;
        repeat (3) @(negedge clk);
        rd_chk("R6 sticky accumulate", 8'h04, 32'h0000_0090);

        // R7: exact output latency on set and on acknowledge
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0000_0008);
        @(negedge clk); irq_in = 16'h0008;
        @(negedge clk); irq_in = '0;
        chk("R7 irq_o one edge after latch", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        chk("R7 irq_o rises", {31'b0, irq_out}, 32'h1);
        addr = 8'h04; we = 1'b1; wdata = 32'h0;
        @(negedge clk); we = 1'b0;
        chk("R7 irq_o holds at clearing edge", {31'b0, irq_out}, 32'h1);
        @(negedge clk);
        chk("R7 irq_o falls", {31'b0, irq_out}, 32'h0);

        // R8: write and enabled line in the same cycle
        wr(8'h00, 32'h0000_0404);
        @(negedge clk);
        addr = 8'h04; we = 1'b1; wdata = 32'h0; irq_in = 16'h0404;
        @(negedge clk);
        we = 1'b0; irq_in = '0;
        rd_chk("R8 write wins", 8'h04, 32'h0);
        chk("R8 irq_o low", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        addr = 8'h04; we = 1'b1; wdata = 32'h0000_0001; irq_in = 16'h0004;
        @(negedge clk);
        we = 1'b0; irq_in = '0;
        rd_chk("R8 write value wins", 8'h04, 32'h0000_0001);
        wr(8'h04, 32'h0);
        wr(8'h00, 32'h0);

        // R9: card detect follows lines 9 and 13, inverted, enable irrelevant
        @(negedge clk); irq_in = 16'h0200;
        rd_chk("R9 socket0 detect low", 8'h08, 32'h400);
        rd_chk("R9 socket1 unaffected", 8'h0C, 32'h420);
        irq_in = 16'h2000;
        rd_chk("R9 socket1 detect low", 8'h0C, 32'h400);
        rd_chk("R9 socket0 restored", 8'h08, 32'h420);
        rd_chk("R9 pending untouched", 8'h04, 32'h0);
        irq_in = '0;

        // R10: socket writes reach only bits [4:0]
        wr(8'h08, 32'hFFFF_FFFF);
        rd_chk("R10 socket0 write all ones", 8'h08, 32'h43F);
        rd_chk("R10 socket1 untouched", 8'h0C, 32'h420);
        wr(8'h0C, 32'h0000_0015);
        @(negedge clk); irq_in = 16'h2000;
        rd_chk("R10 socket1 ctl with detect", 8'h0C, 32'h415);
        irq_in = '0;
        wr(8'h08, 32'h0);
        wr(8'h0C, 32'h0);
        rd_chk("R10 socket0 cleared", 8'h08, 32'h420);

        // R11: unmapped reads return zero, unmapped writes change nothing
        for (int a = 0; a < 256; a++) begin
            if (!((a % 4 == 0) && (a < 'h30))) begin
                wr(8'(a), 32'hDEAD_BEEF);
                rd(8'(a), v);
                chk("R11 unmapped read zero", v, 32'h0);
            end
        end
        check_all("R11 state unchanged", 32'h0, 32'h0);
        chk("R11 irq_o", {31'b0, irq_out}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule